// File: doc/BRIEF.md
# Bulk-In Packet De-aggregator

This block splits one aggregated bulk-in transfer, already stored in a byte-addressable receive buffer, into individual Ethernet frames. It does not move payload bytes. It only works out where each frame sits in the buffer and hands that location to the logic downstream. A start pulse begins the work, together with the transfer's total byte length. The block reads the buffer through a single synchronous byte read port. That port returns data one cycle after it is asked.

The transfer carries a small descriptor trailer in its final four bytes. The trailer gives two things: how many frames were packed, and where a table of per-frame header words begins. Frame payloads are laid out from offset zero, and each one starts on an 8-byte boundary.

For each header the block checks the frame length against the transfer bounds. A frame that passes goes out as an (offset, length, error flags) descriptor on a valid/ready stream. A frame that fails is counted as skipped. A one-cycle done pulse closes the run. Two counters, one for emitted frames and one for skipped frames, let the surrounding logic see how the transfer was consumed.

Top module: `pkt_unbundler`

## Requirements
- R1: The last four bytes of the transfer (addresses L-4 to L-1, where L is the transfer length) are read as a little-endian word. Bits 15:0 of that word are the frame count, and bits 31:16 are the byte address of the first header word.
- R2: When L is below 4, the block issues no buffer read and emits no frame, and done still pulses.
- R3: Header words are little-endian and consecutive. The first header is at the address given by the trailer, and the header address moves up by 4 for each frame processed.
- R4: The frame length is header bits 28:16 (13 bits). Header bits 15:0 and bit 30 have no effect on any output.
- R5: The first frame's offset is 0. After each processed frame, emitted or skipped, the offset moves up by the frame length rounded up to the next multiple of 8.
- R6: The walk ends when any of these holds: the frame count is used up, the header address plus 4 is greater than L, or the data offset has reached or passed L.
- R7: A frame is emitted only if its length is at least 6 and its offset plus its length is no greater than L. Any other frame is skipped and adds one to `skipCount`.
- R8: `pktErr[0]` carries header bit 29 (CRC error) and `pktErr[1]` carries header bit 31 (frame dropped). These flags never stop a frame from being emitted.
- R9: While `pktValid` is high and `pktReady` is low, the block holds the descriptor stable and the walk does not advance. Each cycle with `pktValid` and `pktReady` both high hands over exactly one frame.
- R10: `done` is a single-cycle pulse at the end of a run, and `pktValid` and `rdEn` are low in that cycle. A start while a run is in progress is ignored. Both counters clear when a run is accepted, and `emitCount` equals the number of frames handed over.
- R11: `rdData` returns the byte at `rdAddr` one cycle after `rdEn`, and every read falls within [0, L).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin parsing the transfer (accepted only while idle) |
| xferLen | input | ADDR_W | Transfer length in bytes; held stable for the whole run |
| rdEn | output | 1 | Buffer read request |
| rdAddr | output | ADDR_W | Buffer byte address |
| rdData | input | 8 | Buffer byte, one cycle after the request |
| pktValid | output | 1 | Frame descriptor valid |
| pktReady | input | 1 | Downstream accepts the descriptor |
| pktOffset | output | ADDR_W | Frame start offset in the buffer |
| pktLen | output | 13 | Frame length in bytes |
| pktErr | output | 2 | {drop flag, CRC flag} |
| done | output | 1 | Run-complete pulse |
| emitCount | output | CNT_W | Frames handed over in the current run |
| skipCount | output | CNT_W | Frames rejected in the current run |

## Verification
The assertions assume two things about the inputs. First, `xferLen` does not change from the start pulse until done. Second, the buffer answers every read on the next cycle and its contents do not change during a run. Under those assumptions the assertions check that reads stay inside the transfer, that each emitted descriptor is aligned and in bounds, and that a stalled descriptor holds still. The bench changes `xferLen` and rewrites the buffer only between runs, while the block is idle. Its buffer model has a fixed one-cycle read latency. Every sweep is built so that all addresses the parser can reach lie inside the modelled memory.

// File: rtl/unbundle_pkg.sv
package unbundle_pkg;

  // Field layout of the trailer and header words
  localparam int HDR_BYTES   = 4;
  localparam int CNT_FIELD_W = 16;
  localparam int OFF_LSB     = 16;
  localparam int LEN_LSB     = 16;
  localparam int LEN_W       = 13;
  localparam int CRC_BIT     = 29;
  localparam int DROP_BIT    = 31;
  localparam int ALIGN_LG2   = 3;
  localparam int MIN_PKT     = 6;

  typedef enum logic [3:0] {
    ST_IDLE, ST_LEN, ST_TRAIL, ST_TLOAD, ST_WALK,
    ST_HDR, ST_DECIDE, ST_EMIT, ST_FIN
  } walkState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic       latchLen;
    logic       clrCounts;
    logic       rdIssue;
    logic       useHdrBase;
    logic [1:0] byteSel;
    logic       loadTrailer;
    logic       advance;
    logic       bumpEmit;
    logic       bumpSkip;
  } ctlStrobe_t;

  // Conditions from datapath to control
  typedef struct packed {
    logic tooShort;
    logic countZero;
    logic hdrPastEnd;
    logic posAtEnd;
    logic pktFits;
  } dpStatus_t;

endpackage

// File: rtl/unbundle_dp.sv
module unbundle_dp
  import unbundle_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        ctl,
  input  logic [ADDR_W-1:0] xferLen,
  input  logic [7:0]        rdData,
  output dpStatus_t         status,
  output logic [ADDR_W-1:0] rdAddr,
  output logic [ADDR_W-1:0] pktOffset,
  output logic [LEN_W-1:0]  pktLen,
  output logic [1:0]        pktErr,
  output logic [CNT_W-1:0]  emitCount,
  output logic [CNT_W-1:0]  skipCount
);

  localparam int OFF_W = (ADDR_W > CNT_FIELD_W) ? ADDR_W : CNT_FIELD_W;
  localparam int POS_W = OFF_W + 2;

  logic [ADDR_W-1:0]      lenQ;
  logic [31:0]            wordQ;
  logic                   rdPend;
  logic [CNT_FIELD_W-1:0] pktsLeft;
  logic [POS_W-1:0]       hdrPos;
  logic [POS_W-1:0]       dataPos;

  logic [POS_W-1:0]  lenExt;
  logic [LEN_W-1:0]  curLen;
  logic [POS_W-1:0]  padLen;
  logic [POS_W-1:0]  stepLen;
  logic [ADDR_W-1:0] baseAddr;

  always_comb begin
    lenExt  = POS_W'(lenQ);
    curLen  = wordQ[LEN_LSB +: LEN_W];
    padLen  = POS_W'(curLen) + POS_W'((1 << ALIGN_LG2) - 1);
    stepLen = {padLen[POS_W-1:ALIGN_LG2], {ALIGN_LG2{1'b0}}};

    status.tooShort   = lenQ < ADDR_W'(HDR_BYTES);
    status.countZero  = pktsLeft == '0;
    status.hdrPastEnd = (hdrPos + POS_W'(HDR_BYTES)) > lenExt;
    status.posAtEnd   = dataPos >= lenExt;
    status.pktFits    = (curLen >= LEN_W'(MIN_PKT)) &&
                        ((dataPos + POS_W'(curLen)) <= lenExt);

    baseAddr  = ctl.useHdrBase ? hdrPos[ADDR_W-1:0] : (lenQ - ADDR_W'(HDR_BYTES));
    rdAddr    = baseAddr + ADDR_W'(ctl.byteSel);
    pktOffset = dataPos[ADDR_W-1:0];
    pktLen    = curLen;
    pktErr    = {wordQ[DROP_BIT], wordQ[CRC_BIT]};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lenQ      <= '0;
      wordQ     <= '0;
      rdPend    <= 1'b0;
      pktsLeft  <= '0;
      hdrPos    <= '0;
      dataPos   <= '0;
      emitCount <= '0;
      skipCount <= '0;
    end else begin
      rdPend <= ctl.rdIssue;
      if (ctl.latchLen) lenQ <= xferLen;
      // bytes arrive lowest address first: shift in from the top
      if (rdPend) wordQ <= {rdData, wordQ[31:8]};
      if (ctl.loadTrailer) begin
        pktsLeft <= wordQ[CNT_FIELD_W-1:0];
        hdrPos   <= POS_W'(wordQ[OFF_LSB +: CNT_FIELD_W]);
        dataPos  <= '0;
      end else if (ctl.advance) begin
        pktsLeft <= pktsLeft - 1'b1;
        hdrPos   <= hdrPos + POS_W'(HDR_BYTES);
        dataPos  <= dataPos + stepLen;
      end
      if (ctl.clrCounts) begin
        emitCount <= '0;
        skipCount <= '0;
      end else begin
        if (ctl.bumpEmit) emitCount <= emitCount + 1'b1;
        if (ctl.bumpSkip) skipCount <= skipCount + 1'b1;
      end
    end
  end

endmodule

// File: rtl/unbundle_ctrl.sv
module unbundle_ctrl
  import unbundle_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       pktReady,
  input  dpStatus_t  status,
  output ctlStrobe_t ctl,
  output logic       rdEn,
  output logic       pktValid,
  output logic       done
);

  walkState_t state, stateNext;
  logic [2:0] fetchCnt;
  logic       fetching;
  logic       fetchLast;

  always_comb begin
    ctl       = '0;
    stateNext = state;
    fetching  = (state == ST_TRAIL) || (state == ST_HDR);
    fetchLast = fetchCnt == 3'd4;
    pktValid  = 1'b0;
    done      = 1'b0;

    if (fetching) begin
      ctl.rdIssue    = !fetchCnt[2];
      ctl.byteSel    = fetchCnt[1:0];
      ctl.useHdrBase = state == ST_HDR;
    end

    unique case (state)
      ST_IDLE: if (start) begin
        ctl.latchLen  = 1'b1;
        ctl.clrCounts = 1'b1;
        stateNext     = ST_LEN;
      end
      ST_LEN:   stateNext = status.tooShort ? ST_FIN : ST_TRAIL;
      ST_TRAIL: if (fetchLast) stateNext = ST_TLOAD;
      ST_TLOAD: begin
        ctl.loadTrailer = 1'b1;
        stateNext       = ST_WALK;
      end
      ST_WALK: begin
        if (status.countZero || status.hdrPastEnd || status.posAtEnd)
          stateNext = ST_FIN;
        else
          stateNext = ST_HDR;
      end
      ST_HDR: if (fetchLast) stateNext = ST_DECIDE;
      ST_DECIDE: begin
        if (status.pktFits) begin
          stateNext = ST_EMIT;
        end else begin
          ctl.bumpSkip = 1'b1;
          ctl.advance  = 1'b1;
          stateNext    = ST_WALK;
        end
      end
      ST_EMIT: begin
        pktValid = 1'b1;
        if (pktReady) begin
          ctl.bumpEmit = 1'b1;
          ctl.advance  = 1'b1;
          stateNext    = ST_WALK;
        end
      end
      ST_FIN: begin
        done      = 1'b1;
        stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase

    rdEn = ctl.rdIssue;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      fetchCnt <= '0;
    end else begin
      state <= stateNext;
      if (stateNext != state) fetchCnt <= '0;
      else if (fetching)      fetchCnt <= fetchCnt + 1'b1;
    end
  end

endmodule

// File: rtl/pkt_unbundler.sv
module pkt_unbundler
  import unbundle_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [ADDR_W-1:0] xferLen,
  output logic              rdEn,
  output logic [ADDR_W-1:0] rdAddr,
  input  logic [7:0]        rdData,
  output logic              pktValid,
  input  logic              pktReady,
  output logic [ADDR_W-1:0] pktOffset,
  output logic [LEN_W-1:0]  pktLen,
  output logic [1:0]        pktErr,
  output logic              done,
  output logic [CNT_W-1:0]  emitCount,
  output logic [CNT_W-1:0]  skipCount
);

  ctlStrobe_t ctl;
  dpStatus_t  status;

  unbundle_ctrl i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .pktReady (pktReady),
    .status   (status),
    .ctl      (ctl),
    .rdEn     (rdEn),
    .pktValid (pktValid),
    .done     (done)
  );

  unbundle_dp #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .xferLen   (xferLen),
    .rdData    (rdData),
    .status    (status),
    .rdAddr    (rdAddr),
    .pktOffset (pktOffset),
    .pktLen    (pktLen),
    .pktErr    (pktErr),
    .emitCount (emitCount),
    .skipCount (skipCount)
  );

endmodule

// File: rtl/unbundle_chk.sv
module unbundle_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] xferLen,
  input logic              rdEn,
  input logic [ADDR_W-1:0] rdAddr,
  input logic              pktValid,
  input logic              pktReady,
  input logic [ADDR_W-1:0] pktOffset,
  input logic [12:0]       pktLen,
  input logic [1:0]        pktErr,
  input logic              done
);

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    pktValid && !pktReady |=> pktValid && $stable(pktOffset) && $stable(pktLen) && $stable(pktErr)); // R9

  AST_MIN_LEN: assert property (@(posedge clk) disable iff (!rstN)
    pktValid |-> pktLen >= 13'd6); // R7

  AST_IN_BOUNDS: assert property (@(posedge clk) disable iff (!rstN)
    pktValid |-> (int'(pktOffset) + int'(pktLen)) <= int'(xferLen)); // R7

  AST_ALIGNED: assert property (@(posedge clk) disable iff (!rstN)
    pktValid |-> pktOffset[2:0] == 3'b000); // R5

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R10

  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !pktValid && !rdEn); // R10

  AST_READ_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    rdEn |-> rdAddr < xferLen); // R11

  AST_SHORT_NO_READ: assert property (@(posedge clk) disable iff (!rstN)
    xferLen < 4 |-> !rdEn); // R2

endmodule

bind pkt_unbundler unbundle_chk #(.ADDR_W(ADDR_W)) i_chk (
  .clk       (clk),
  .rstN      (rstN),
  .xferLen   (xferLen),
  .rdEn      (rdEn),
  .rdAddr    (rdAddr),
  .pktValid  (pktValid),
  .pktReady  (pktReady),
  .pktOffset (pktOffset),
  .pktLen    (pktLen),
  .pktErr    (pktErr),
  .done      (done)
);

// File: tb/test_pkt_unbundler.sv
`timescale 1ns/1ps
module test_pkt_unbundler;

  localparam int ADDR_W = 16;
  localparam int CNT_W  = 16;
  localparam int MEM_SZ = 2048;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              start = 1'b0;
  logic [ADDR_W-1:0] xferLen = '0;
  logic              rdEn;
  logic [ADDR_W-1:0] rdAddr;
  logic [7:0]        rdData;
  logic              pktValid;
  logic              pktReady = 1'b1;
  logic [ADDR_W-1:0] pktOffset;
  logic [12:0]       pktLen;
  logic [1:0]        pktErr;
  logic              done;
  logic [CNT_W-1:0]  emitCount;
  logic [CNT_W-1:0]  skipCount;

  always #2 clk = ~clk;

  pkt_unbundler #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) i_pkt_unbundler (.*);

  logic [7:0] mem [0:MEM_SZ-1];
  always_ff @(posedge clk) if (rdEn) rdData <= mem[rdAddr[10:0]];

  int nChecks = 0;
  int nErr    = 0;
  int expOff [0:31];
  int expLen [0:31];
  int expErr [0:31];
  int expN, expSkip, gotN, rdSeen, negCyc, rdyMode;
  int cycles = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int rd32(input int a);
    return {mem[a+3], mem[a+2], mem[a+1], mem[a]};
  endfunction

  task automatic wr32(input int a, input int v);
    for (int k = 0; k < 4; k++) mem[a+k] = 8'(v >> (8*k));
  endtask

  // Reference walk written from the requirements
  task automatic computeExpected(input int len);
    int tr, cnt, h, pos, hw, pl;
    expN = 0; expSkip = 0;
    if (len < 4) return;
    tr  = rd32(len - 4);
    cnt = tr & 32'hFFFF;
    h   = (tr >> 16) & 32'hFFFF;
    pos = 0;
    while (cnt > 0) begin
      if (h + 4 > len) break;
      if (pos >= len) break;
      hw = rd32(h);
      pl = (hw >> 16) & 32'h1FFF;
      if (pl >= 6 && pos + pl <= len) begin
        expOff[expN] = pos; expLen[expN] = pl;
        expErr[expN] = (((hw >> 31) & 1) << 1) | ((hw >> 29) & 1);
        expN++;
      end else expSkip++;
      pos += ((pl + 7) / 8) * 8;
      h   += 4;
      cnt--;
    end
  endtask

  // Ready pattern, handshake monitor, read counter
  always @(negedge clk) begin
    negCyc++;
    pktReady = (rdyMode == 0) || ((negCyc % 3) != 0);
    if (rdEn) rdSeen++;
    if (pktValid && pktReady) begin
      if (gotN >= expN) begin
        chk(1'b0, "R7", "unexpected frame index", gotN, expN);
      end else begin
        chk(int'(pktOffset) == expOff[gotN], "R5", "frame offset", int'(pktOffset), expOff[gotN]);
        chk(int'(pktLen) == expLen[gotN], "R4", "frame length", int'(pktLen), expLen[gotN]);
        chk(int'(pktErr) == expErr[gotN], "R8", "error flags", int'(pktErr), expErr[gotN]);
      end
      gotN++;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      nChecks++; nErr++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 150000);
      $display("Result: errors=%0d of %0d checks", nErr, nChecks);
      $finish;
    end
  end

  task automatic runScenario(input int len, input bit poke);
    int waitCyc;
    @(negedge clk);
    xferLen = ADDR_W'(len);
    computeExpected(len);
    gotN = 0; rdSeen = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      repeat (2) @(negedge clk);
      start = 1'b1;                       // R10: ignored while busy
      @(negedge clk);
      start = 1'b0;
    end
    waitCyc = 0;
    while (!done && waitCyc < 4000) begin
      @(negedge clk);
      waitCyc++;
    end
    chk(done == 1'b1, "R10", "done pulse seen", int'(done), 1);
    chk(gotN == expN, "R9", "frames handed over", gotN, expN);
    chk(int'(emitCount) == expN, "R10", "emitCount", int'(emitCount), expN);
    chk(int'(skipCount) == expSkip, "R7", "skipCount", int'(skipCount), expSkip);
    @(negedge clk);
    chk(done == 1'b0, "R10", "done single cycle", int'(done), 0);
  endtask

  task automatic buildSweep(input int n, input int v, output int len);
    int lenTab [0:7] = '{0, 5, 6, 7, 8, 13, 60, 100};
    int lens [0:7];
    int pos, hoff, hw;
    for (int a = 0; a < MEM_SZ; a++) mem[a] = 8'((a * 7 + v) & 255);
    pos = 0;
    for (int i = 0; i < n; i++) begin
      lens[i] = lenTab[(i * 3 + v) % 8];
      if (v == 5 && i == 0) lens[i] = 8191;
      else pos += ((lens[i] + 7) / 8) * 8;
    end
    hoff = pos + ((v == 4) ? 16 : 0);
    for (int i = 0; i < n; i++) begin
      hw = (lens[i] << 16) | (1 << 30) | ((16'hA5 ^ i) & 16'hFFFF);
      if (i % 2 == 1) hw |= (1 << 29);
      if ((i + v) % 3 == 0) hw |= (1 << 31);
      wr32(hoff + 4 * i, hw);
    end
    len = hoff + 4 * n + 4;
    wr32(len - 4, (hoff << 16) | (n + ((v == 3) ? 2 : 0)));
  endtask

  initial begin
    int len;
    rdyMode = 0; negCyc = 0; gotN = 0; expN = 0; rdSeen = 0;
    for (int a = 0; a < MEM_SZ; a++) mem[a] = 8'hC3;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(pktValid == 1'b0, "R9", "reset pktValid", int'(pktValid), 0);
    chk(done == 1'b0, "R10", "reset done", int'(done), 0);
    chk(rdEn == 1'b0, "R11", "reset rdEn", int'(rdEn), 0);
    chk(emitCount == '0 && skipCount == '0, "R10", "reset counters", int'(emitCount) + int'(skipCount), 0);

    // R2: short transfers
    for (int l = 0; l < 4; l++) begin
      runScenario(l, 1'b0);
      chk(rdSeen == 0, "R2", "reads on short transfer", rdSeen, 0);
      chk(gotN == 0, "R2", "frames on short transfer", gotN, 0);
    end

    // R1 R3 R5 R6 R7 R8: sweep of frame counts and layouts
    for (int n = 0; n <= 5; n++) begin
      for (int v = 0; v <= 5; v++) begin
        buildSweep(n, v, len);
        rdyMode = (n + v) % 2;
        runScenario(len, (v == 2));
      end
    end

    // R7: frame ending exactly at the transfer end, then one byte over
    for (int extra = 0; extra < 2; extra++) begin
      for (int a = 0; a < 64; a++) mem[a] = 8'h11;
      wr32(0, (8 + extra) << 16);
      wr32(4, 1);                          // count 1, header at 0
      rdyMode = 0;
      runScenario(8, 1'b0);
      chk(int'(emitCount) == 1 - extra, "R7", "exact-fit boundary", int'(emitCount), 1 - extra);
    end

    // R6: header table placed past the end stops at once
    for (int a = 0; a < 64; a++) mem[a] = 8'h00;
    wr32(28, (30 << 16) | 3);
    runScenario(32, 1'b0);
    chk(int'(skipCount) == 0 && int'(emitCount) == 0, "R6", "header past end", int'(skipCount) + int'(emitCount), 0);

    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

endmodule